// File: doc/BRIEF.md
# Transceiver Channel Reset Sequencer

This block produces the ordered reset controls for one serial transceiver channel. It runs from a free-running clock and a system reset, and drives a PLL power-down, an analog reset and a digital reset for each of the transmit and receive paths, plus a ready flag for each path. On system reset it holds the PLL powered down for a programmable time and then releases it. After that it frees the analog resets and, once the relevant lock and calibration status has stayed good for a programmable settle window, the digital resets.

All status inputs are asynchronous and pass through a two-stage synchroniser before use. Each digital reset has a mode input. In automatic mode, loss of the matching lock after release forces the path back into reset. In manual mode the path stays released, so rate-change logic running in the channel is not disturbed. The PLL calibration-busy input is used only when the `USE_PLL_CAL` parameter is 1. When it is 0, the integrator must OR the PLL calibration-busy into the transmit calibration-busy input.

Top module: `xcvr_rst_seq`

## Requirements
- R1: After the system reset is released, `pll_pwrdn` stays high for exactly `PD_CYCLES` rising clock edges, then goes low and stays low until the next system reset.
- R2: `tx_ana_rst` is high whenever `pll_pwrdn` is high, and falls one clock edge after `pll_pwrdn` falls.
- R3: `tx_dig_rst` is released only after the synchronised PLL lock has been high, and the transmit calibration busy low, for `TX_SETTLE` consecutive edges with `tx_ana_rst` low. From a rising `pll_locked` (other conditions good) to the fall of `tx_dig_rst` takes 2 + `TX_SETTLE` edges. A shorter good window does not release it.
- R4: With `USE_PLL_CAL` = 1, a high `pll_cal_busy` blocks the release of `tx_dig_rst` in the same way as a high `tx_cal_busy`.
- R5: With `tx_dig_manual` = 0 (automatic), a fall of `pll_locked` after release re-asserts `tx_dig_rst` on the third rising edge after the fall.
- R6: With `tx_dig_manual` = 1 (manual), loss of PLL lock leaves a released `tx_dig_rst` low.
- R7: `rx_ana_rst` is released once `pll_pwrdn` is low, the synchronised `rx_cal_busy` is low and the synchronised `rx_locked_ref` is high. It falls on the third rising edge after the last of the two inputs becomes good.
- R8: `rx_dig_rst` is released after `rx_locked_data` has been high for `RX_SETTLE` consecutive edges with `rx_ana_rst` low. The fall comes 2 + `RX_SETTLE` edges after `rx_locked_data` rises.
- R9: In automatic mode (`rx_dig_manual` = 0), a fall of `rx_locked_data` re-asserts `rx_dig_rst` on the third rising edge. In manual mode (`rx_dig_manual` = 1) it stays released.
- R10: `tx_ready` equals the inverse of `tx_dig_rst` and `rx_ready` equals the inverse of `rx_dig_rst`, in the same cycle.
- R11: While the system reset is high, `pll_pwrdn` and all four reset outputs are high and both ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | System reset, active high, asynchronous assert |
| tx_dig_manual | input | 1 | 1 = manual mode for the transmit digital reset |
| rx_dig_manual | input | 1 | 1 = manual mode for the receive digital reset |
| pll_locked | input | 1 | Transmit PLL locked (async) |
| pll_cal_busy | input | 1 | PLL calibration busy (async), used when USE_PLL_CAL = 1 |
| tx_cal_busy | input | 1 | Transmit calibration busy (async) |
| rx_cal_busy | input | 1 | Receive calibration busy (async) |
| rx_locked_ref | input | 1 | Receive CDR locked to reference (async) |
| rx_locked_data | input | 1 | Receive CDR locked to data (async) |
| pll_pwrdn | output | 1 | PLL power-down |
| tx_ana_rst | output | 1 | Transmit analog reset |
| tx_dig_rst | output | 1 | Transmit digital reset |
| rx_ana_rst | output | 1 | Receive analog reset |
| rx_dig_rst | output | 1 | Receive digital reset |
| tx_ready | output | 1 | Transmit path out of reset |
| rx_ready | output | 1 | Receive path out of reset |

## Verification
The assertions check the ordering rules on every cycle. Power-down never returns without a system reset. The transmit analog reset covers the power-down. A digital reset never falls while its analog reset or the power-down is high. A released digital reset in manual mode stays released, and neither ready flag is high during power-down. The exact cycle counts can only be shown by the bench's scenarios: the power-down length, the 2 + settle release latency, the third-edge re-assertion after lock loss, and the rejection of a too-short good window.

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int PD_CYCLES  = 16,
  parameter int TX_SETTLE  = 8,
  parameter int RX_SETTLE  = 8,
  parameter bit USE_PLL_CAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_dig_manual,
  input  logic rx_dig_manual,
  input  logic pll_locked,
  input  logic pll_cal_busy,
  input  logic tx_cal_busy,
  input  logic rx_cal_busy,
  input  logic rx_locked_ref,
  input  logic rx_locked_data,
  output logic pll_pwrdn,
  output logic tx_ana_rst,
  output logic tx_dig_rst,
  output logic rx_ana_rst,
  output logic rx_dig_rst,
  output logic tx_ready,
  output logic rx_ready
);
  localparam int PD_W = $clog2(PD_CYCLES + 1);
  localparam int TX_W = $clog2(TX_SETTLE + 1);
  localparam int RX_W = $clog2(RX_SETTLE + 1);
  localparam logic [PD_W-1:0] PD_LAST = PD_W'(PD_CYCLES - 1);
  localparam logic [TX_W-1:0] TX_LAST = TX_W'(TX_SETTLE - 1);
  localparam logic [RX_W-1:0] RX_LAST = RX_W'(RX_SETTLE - 1);

  logic [5:0] meta_q, sync_q;
  logic [PD_W-1:0] pd_cnt;
  logic [TX_W-1:0] tx_cnt;
  logic [RX_W-1:0] rx_cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {pll_locked, pll_cal_busy, tx_cal_busy,
                 rx_cal_busy, rx_locked_ref, rx_locked_data};
      sync_q <= meta_q;
    end
  end

  wire s_pll_lock  = sync_q[5];
  wire s_pll_cal   = sync_q[4];
  wire s_tx_cal    = sync_q[3];
  wire s_rx_cal    = sync_q[2];
  wire s_rx_lref   = sync_q[1];
  wire s_rx_ldata  = sync_q[0];

  wire tx_busy = s_tx_cal | (USE_PLL_CAL & s_pll_cal);
  wire tx_ok   = ~tx_ana_rst & s_pll_lock & ~tx_busy;
  wire rx_ok   = ~rx_ana_rst & s_rx_ldata;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pll_pwrdn <= 1'b1;
      pd_cnt    <= '0;
    end else if (pll_pwrdn) begin
      pd_cnt <= pd_cnt + 1'b1;
      if (pd_cnt == PD_LAST) pll_pwrdn <= 1'b0;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) tx_ana_rst <= 1'b1;
    else     tx_ana_rst <= pll_pwrdn;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) rx_ana_rst <= 1'b1;
    else if (!pll_pwrdn && !s_rx_cal && s_rx_lref) rx_ana_rst <= 1'b0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tx_dig_rst <= 1'b1;
      tx_cnt     <= '0;
    end else begin
      tx_cnt <= (tx_ok && tx_dig_rst) ? tx_cnt + 1'b1 : '0;
      if (tx_dig_rst) begin
        if (tx_ok && tx_cnt == TX_LAST) tx_dig_rst <= 1'b0;
      end else if (!tx_dig_manual && !s_pll_lock) begin
        tx_dig_rst <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rx_dig_rst <= 1'b1;
      rx_cnt     <= '0;
    end else begin
      rx_cnt <= (rx_ok && rx_dig_rst) ? rx_cnt + 1'b1 : '0;
      if (rx_dig_rst) begin
        if (rx_ok && rx_cnt == RX_LAST) rx_dig_rst <= 1'b0;
      end else if (!rx_dig_manual && !s_rx_ldata) begin
        rx_dig_rst <= 1'b1;
      end
    end
  end

  assign tx_ready = ~tx_dig_rst;
  assign rx_ready = ~rx_dig_rst;
endmodule

// File: rtl/xcvr_rst_seq_chk.sv
module xcvr_rst_seq_chk (
  input logic clk,
  input logic rst,
  input logic tx_dig_manual,
  input logic rx_dig_manual,
  input logic pll_pwrdn,
  input logic tx_ana_rst,
  input logic tx_dig_rst,
  input logic rx_ana_rst,
  input logic rx_dig_rst,
  input logic tx_ready,
  input logic rx_ready
);
  assert_pwrdn_stays_low_R1: assert property (@(posedge clk) disable iff (rst)
    !pll_pwrdn |=> !pll_pwrdn);

  assert_tx_ana_covers_pwrdn_R2: assert property (@(posedge clk) disable iff (rst)
    pll_pwrdn |-> tx_ana_rst);

  assert_tx_dig_after_ana_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_dig_rst) |-> (!tx_ana_rst && !pll_pwrdn));

  assert_rx_dig_after_ana_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_dig_rst) |-> !rx_ana_rst);

  assert_rx_ana_after_pwrdn_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_ana_rst) |-> !pll_pwrdn);

  assert_tx_manual_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_dig_manual && !tx_dig_rst) |=> !tx_dig_rst);

  assert_rx_manual_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_dig_manual && !rx_dig_rst) |=> !rx_dig_rst);

  assert_no_ready_in_pwrdn_R10: assert property (@(posedge clk) disable iff (rst)
    pll_pwrdn |-> (!tx_ready && !rx_ready));
endmodule

bind xcvr_rst_seq xcvr_rst_seq_chk chk_i (
  .clk(clk), .rst(rst),
  .tx_dig_manual(tx_dig_manual), .rx_dig_manual(rx_dig_manual),
  .pll_pwrdn(pll_pwrdn), .tx_ana_rst(tx_ana_rst), .tx_dig_rst(tx_dig_rst),
  .rx_ana_rst(rx_ana_rst), .rx_dig_rst(rx_dig_rst),
  .tx_ready(tx_ready), .rx_ready(rx_ready)
);

// File: tb/xcvr_rst_seq_tb_top.sv
module xcvr_rst_seq_tb_top;
  localparam int PD = 16, TXS = 8, RXS = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic tx_man = 1'b0, rx_man = 1'b0;
  logic pll_locked = 1'b0, pll_cal_busy = 1'b1, tx_cal_busy = 1'b1;
  logic rx_cal_busy = 1'b1, rx_locked_ref = 1'b0, rx_locked_data = 1'b0;
  logic pll_pwrdn, tx_ana_rst, tx_dig_rst, rx_ana_rst, rx_dig_rst, tx_ready, rx_ready;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  xcvr_rst_seq #(.PD_CYCLES(PD), .TX_SETTLE(TXS), .RX_SETTLE(RXS), .USE_PLL_CAL(1'b1)) dut_i (
    .clk(clk), .rst(rst), .tx_dig_manual(tx_man), .rx_dig_manual(rx_man),
    .pll_locked(pll_locked), .pll_cal_busy(pll_cal_busy), .tx_cal_busy(tx_cal_busy),
    .rx_cal_busy(rx_cal_busy), .rx_locked_ref(rx_locked_ref), .rx_locked_data(rx_locked_data),
    .pll_pwrdn(pll_pwrdn), .tx_ana_rst(tx_ana_rst), .tx_dig_rst(tx_dig_rst),
    .rx_ana_rst(rx_ana_rst), .rx_dig_rst(rx_dig_rst), .tx_ready(tx_ready), .rx_ready(rx_ready));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic t_reset;
    step(2);
    chk(pll_pwrdn && tx_ana_rst && tx_dig_rst && rx_ana_rst && rx_dig_rst,
        "R11 resets high in reset", {pll_pwrdn, tx_ana_rst, tx_dig_rst, rx_ana_rst, rx_dig_rst}, 31);
    chk(!tx_ready && !rx_ready, "R11 ready low in reset", {tx_ready, rx_ready}, 0);
  endtask

  task automatic t_powerdown;
    int n = 0;
    rst = 1'b0;
    while (pll_pwrdn && n < 200) begin n++; step(1); end
    chk(n == PD, "R1 power-down length", n, PD);
    chk(tx_ana_rst == 1'b1, "R2 tx analog still high at power-down fall", tx_ana_rst, 1);
    step(1);
    chk(tx_ana_rst == 1'b0, "R2 tx analog falls one edge later", tx_ana_rst, 0);
    chk(tx_dig_rst == 1'b1, "R3 tx digital held without lock", tx_dig_rst, 1);
  endtask

  task automatic t_rx_ana;
    rx_cal_busy = 1'b0;
    rx_locked_ref = 1'b1;
    step(2);
    chk(rx_ana_rst == 1'b1, "R7 rx analog held two edges", rx_ana_rst, 1);
    step(1);
    chk(rx_ana_rst == 1'b0, "R7 rx analog released on third edge", rx_ana_rst, 0);
  endtask

  task automatic t_tx_release;
    int n = 0;
    pll_locked = 1'b1;
    tx_cal_busy = 1'b0;
    step(30);
    chk(tx_dig_rst == 1'b1, "R4 pll_cal_busy blocks tx release", tx_dig_rst, 1);
    pll_cal_busy = 1'b0;
    step(TXS - 2);
    pll_cal_busy = 1'b1;
    step(12);
    chk(tx_dig_rst == 1'b1, "R3 short good window rejected", tx_dig_rst, 1);
    pll_cal_busy = 1'b0;
    while (tx_dig_rst && n < 200) begin step(1); n++; end
    chk(n == 2 + TXS, "R3 tx release latency", n, 2 + TXS);
    chk(tx_ready == 1'b1, "R10 tx_ready with release", tx_ready, 1);
  endtask

  task automatic t_tx_auto;
    int n = 0;
    pll_locked = 1'b0;
    step(2);
    chk(tx_dig_rst == 1'b0, "R5 tx digital low two edges after loss", tx_dig_rst, 0);
    step(1);
    chk(tx_dig_rst == 1'b1, "R5 auto re-assert on third edge", tx_dig_rst, 1);
    chk(tx_ready == 1'b0, "R10 tx_ready drops with reset", tx_ready, 0);
    pll_locked = 1'b1;
    while (tx_dig_rst && n < 200) begin step(1); n++; end
    chk(n == 2 + TXS, "R3 tx re-release latency", n, 2 + TXS);
  endtask

  task automatic t_tx_manual;
    int n = 0;
    tx_man = 1'b1;
    step(1);
    pll_locked = 1'b0;
    step(20);
    chk(tx_dig_rst == 1'b0 && tx_ready == 1'b1, "R6 manual ignores lock loss", tx_dig_rst, 0);
    pll_locked = 1'b1;
    step(4);
    tx_man = 1'b0;
    step(20);
    chk(tx_dig_rst == 1'b0, "R6 stays released after lock returns", tx_dig_rst, 0);
  endtask

  task automatic t_rx_dig;
    int n = 0;
    rx_locked_data = 1'b1;
    while (rx_dig_rst && n < 200) begin step(1); n++; end
    chk(n == 2 + RXS, "R8 rx release latency", n, 2 + RXS);
    chk(rx_ready == 1'b1, "R10 rx_ready with release", rx_ready, 1);
    rx_locked_data = 1'b0;
    step(2);
    chk(rx_dig_rst == 1'b0, "R9 rx digital low two edges after loss", rx_dig_rst, 0);
    step(1);
    chk(rx_dig_rst == 1'b1 && rx_ready == 1'b0, "R9 rx auto re-assert third edge", rx_dig_rst, 1);
    rx_locked_data = 1'b1;
    n = 0;
    while (rx_dig_rst && n < 200) begin step(1); n++; end
    chk(n == 2 + RXS, "R8 rx re-release latency", n, 2 + RXS);
    rx_man = 1'b1;
    step(1);
    rx_locked_data = 1'b0;
    step(20);
    chk(rx_dig_rst == 1'b0 && rx_ready == 1'b1, "R9 rx manual ignores lock loss", rx_dig_rst, 0);
    chk(pll_pwrdn == 1'b0, "R1 power-down stays low", pll_pwrdn, 0);
  endtask

  initial begin
    t_reset;
    t_powerdown;
    t_rx_ana;
    t_tx_release;
    t_tx_auto;
    t_tx_manual;
    t_rx_dig;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule